// File: doc/BRIEF.md
# Load/Store Unit with Linked Reservation

This unit carries out the memory instructions of a 32-bit little-endian RISC core. Each request supplies a base register value, a signed 16-bit displacement, an operation code and, for stores, the source register value. In the cycle of the request the unit drives a word-wide synchronous memory port with a word address, byte enables, lane-aligned write data and read or write strobes. One cycle later it returns a response: read data, zero- or sign-extended from the addressed byte lanes, or the store-conditional result, together with a writeback flag and an alignment error flag.

A single reservation, made up of a valid bit and a word address, supports atomic read-modify-write sequences. A load-linked sets the reservation. A later store-conditional writes memory only while the reservation is still valid and names the same word. Any local store or externally reported write to the reserved word cancels the reservation, and every store-conditional consumes it. A snoop input carries word addresses written by other agents.

Top module: `lsu_unit`

## Requirements
- R1: `op_i` encodes 0=signed byte load, 1=signed half load, 2=word load, 4=unsigned byte load, 5=unsigned half load, 6=load-linked, 8=byte store, 9=half store, 10=word store, 14=store-conditional. Every request raises `rsp_valid_o` exactly one cycle later. `rsp_wb_o` is set for loads, load-linked and store-conditional, and is clear for plain stores. After reset no response and no memory strobe is active.
- R2: The effective address is `base_i` plus `disp_i` sign-extended to 32 bits. `mem_addr_o` carries bits 31:2 of that address in the request cycle.
- R3: Byte enables use bit n for byte lane n (bits 8n+7:8n). A byte access uses the single lane given by address bits 1:0. A half-word access uses 0011 when address bit 1 is 0 and 1100 when it is 1. A word access uses 1111.
- R4: Store data is replicated on every lane: the low byte four times for a byte store, the low half-word twice for a half store, and the whole word for a word store.
- R5: Unsigned byte and half-word loads return the addressed lanes zero-extended to 32 bits.
- R6: Signed byte and half-word loads copy the top bit of the addressed lanes into all upper bits of the result.
- R7: Word loads and load-linked return the full memory word.
- R8: A half-word access with address bit 0 set, or a word access with address bits 1:0 not both zero, raises `rsp_err_o`. It asserts neither `mem_we_o` nor `mem_re_o` and does not set `rsp_wb_o`.
- R9: A store-conditional to the word reserved by an earlier load-linked, with no write to that word in between, writes the word and returns 1.
- R10: A store-conditional returns 0 and performs no write when no reservation exists (including directly after reset) or when its word differs from the reserved one.
- R11: A local store, or a snoop write to the reserved word, cancels the reservation. Writes to other words leave it intact.
- R12: Every store-conditional cancels the reservation, so a second one without a new load-linked fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| op_i | input | 4 | Operation code |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Source register value for stores |
| snoop_we_i | input | 1 | Another agent writes memory |
| snoop_wa_i | input | 30 | Word address of that write |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 30 | Memory word address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the read strobe |
| rsp_valid_o | output | 1 | Response valid |
| rsp_wb_o | output | 1 | Result is written to the register |
| rsp_err_o | output | 1 | Alignment error |
| rsp_data_o | output | 32 | Load data or store-conditional result |

## Verification
The bench targets lane selection at every byte offset, using bytes with the top bit both set and clear. A design that extended on the wrong bit, or ignored the unsigned flag, would return the wrong upper bits. It adds a negative displacement that crosses a 64 KiB boundary, which catches a design that zero-extends the displacement. Misaligned accesses are checked for the absence of any memory write afterwards, which exposes a design that flags the error but still stores. The reservation is exercised by a store-conditional after reset, one to a mismatched word, one repeated, one after a same-word snoop and one after a same-word local store. Each of these must fail, while snoops and stores to other words must not cancel it; a design that ignored or over-applied a cancel condition would flip one of those results.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [3:0] {
    OP_LB  = 4'h0,
    OP_LH  = 4'h1,
    OP_LW  = 4'h2,
    OP_LBU = 4'h4,
    OP_LHU = 4'h5,
    OP_LL  = 4'h6,
    OP_SB  = 4'h8,
    OP_SH  = 4'h9,
    OP_SW  = 4'hA,
    OP_SC  = 4'hE
  } lsu_op_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} lsu_size_e;

  typedef struct packed {
    logic      is_store;
    logic      link;
    logic      uns;
    lsu_size_e size;
  } lsu_dec_t;

  function automatic lsu_dec_t lsu_decode(logic [3:0] op);
    lsu_dec_t d;
    d.is_store = op[3];
    d.link     = op[2] & (op[1:0] == 2'd2);
    d.uns      = ~op[3] & op[2] & (op[1:0] != 2'd2);
    d.size     = (op[1:0] == 2'd3) ? SZ_W : lsu_size_e'(op[1:0]);
    return d;
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  lsu_size_e         size_i,
  output logic [WA_W-1:0]   wa_o,
  output logic [1:0]        off_o,
  output logic              misalign_o,
  output logic [LANES-1:0]  be_o
);
  logic [ADDR_W-1:0] ea;

  assign ea    = base_i + {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign wa_o  = ea[ADDR_W-1:2];
  assign off_o = ea[1:0];

  always_comb begin
    unique case (size_i)
      SZ_B:    misalign_o = 1'b0;
      SZ_H:    misalign_o = ea[0];
      default: misalign_o = |ea[1:0];
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_B:    be_o = 4'b0001 << ea[1:0];
      SZ_H:    be_o = ea[1] ? 4'b1100 : 4'b0011;
      default: be_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes
  import lsu_pkg::*;
(
  input  lsu_size_e         st_size_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [DATA_W-1:0] st_data_o,
  input  lsu_size_e         ld_size_i,
  input  logic [1:0]        ld_off_i,
  input  logic              ld_uns_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] ld_data_o
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    unique case (st_size_i)
      SZ_B:    st_data_o = {LANES{st_data_i[7:0]}};
      SZ_H:    st_data_o = {(LANES/2){st_data_i[15:0]}};
      default: st_data_o = st_data_i;
    endcase
  end

  assign shifted = rdata_i >> {ld_off_i, 3'b000};

  always_comb begin
    unique case (ld_size_i)
      SZ_B:    ld_data_o = {{(DATA_W-8){~ld_uns_i & shifted[7]}}, shifted[7:0]};
      SZ_H:    ld_data_o = {{(DATA_W-16){~ld_uns_i & shifted[15]}}, shifted[15:0]};
      default: ld_data_o = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_resv.sv
module lsu_resv #(
  parameter int WA_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ll_i,
  input  logic            sc_i,
  input  logic            st_i,
  input  logic [WA_W-1:0] wa_i,
  input  logic            snoop_we_i,
  input  logic [WA_W-1:0] snoop_wa_i,
  output logic            hit_o
);
  logic            valid_q;
  logic [WA_W-1:0] addr_q;
  logic [WA_W-1:0] watch_wa;

  assign hit_o    = valid_q && (addr_q == wa_i);
  assign watch_wa = ll_i ? wa_i : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (ll_i) begin
        valid_q <= 1'b1;
        addr_q  <= wa_i;
      end else if (sc_i || (st_i && hit_o)) begin
        valid_q <= 1'b0;
      end
      if (snoop_we_i && (snoop_wa_i == watch_wa)) valid_q <= 1'b0;
    end
  end

  assert_sc_consumes_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_i |=> !valid_q);
  assert_snoop_cancels_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_we_i && valid_q && !ll_i && snoop_wa_i == addr_q) |=> !valid_q);
  assert_ll_reserves_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ll_i && !(snoop_we_i && snoop_wa_i == wa_i)) |=> (valid_q && addr_q == $past(wa_i)));
  assert_idle_keeps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ll_i && !sc_i && !st_i && !snoop_we_i) |=> (valid_q && $stable(addr_q)));
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              snoop_we_i,
  input  logic [WA_W-1:0]   snoop_wa_i,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [WA_W-1:0]   mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_wb_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  lsu_dec_t          dec;
  logic [1:0]        off;
  logic              misalign;
  logic              is_sc, is_ll, resv_hit, ok;
  logic [DATA_W-1:0] ld_data;

  logic              valid_q, wb_q, err_q, sc_q, sc_ok_q, uns_q;
  lsu_size_e         size_q;
  logic [1:0]        off_q;

  assign dec   = lsu_decode(op_i);
  assign ok    = req_i && !misalign;
  assign is_sc = req_i && dec.is_store && dec.link;
  assign is_ll = ok && !dec.is_store && dec.link;

  lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .base_i     (base_i),
    .disp_i     (disp_i),
    .size_i     (dec.size),
    .wa_o       (mem_addr_o),
    .off_o      (off),
    .misalign_o (misalign),
    .be_o       (mem_be_o)
  );

  lsu_lanes u_lanes (
    .st_size_i (dec.size),
    .st_data_i (wdata_i),
    .st_data_o (mem_wdata_o),
    .ld_size_i (size_q),
    .ld_off_i  (off_q),
    .ld_uns_i  (uns_q),
    .rdata_i   (mem_rdata_i),
    .ld_data_o (ld_data)
  );

  lsu_resv #(.WA_W(WA_W)) u_resv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ll_i       (is_ll),
    .sc_i       (is_sc),
    .st_i       (mem_we_o),
    .wa_i       (mem_addr_o),
    .snoop_we_i (snoop_we_i),
    .snoop_wa_i (snoop_wa_i),
    .hit_o      (resv_hit)
  );

  assign mem_re_o = ok && !dec.is_store;
  assign mem_we_o = ok && dec.is_store && (!dec.link || resv_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wb_q    <= 1'b0;
      err_q   <= 1'b0;
      sc_q    <= 1'b0;
      sc_ok_q <= 1'b0;
      uns_q   <= 1'b0;
      size_q  <= SZ_W;
      off_q   <= 2'b00;
    end else begin
      valid_q <= req_i;
      err_q   <= req_i && misalign;
      wb_q    <= ok && (!dec.is_store || dec.link);
      sc_q    <= is_sc;
      sc_ok_q <= is_sc && mem_we_o;
      if (mem_re_o) begin
        uns_q  <= dec.uns;
        size_q <= dec.size;
        off_q  <= off;
      end
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_wb_o    = wb_q;
  assign rsp_err_o   = err_q;
  assign rsp_data_o  = !wb_q ? '0 : sc_q ? {{(DATA_W-1){1'b0}}, sc_ok_q} : ld_data;

  assert_rsp_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_no_stray_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  assert_misalign_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && misalign) |-> (!mem_we_o && !mem_re_o));
  assert_misalign_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && misalign) |=> (rsp_err_o && !rsp_wb_o));
  assert_byte_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && dec.size == SZ_B) |-> $onehot(mem_be_o));
  assert_half_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && dec.size == SZ_H) |-> ($countones(mem_be_o) == 2));
  assert_sc_bool_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && !misalign) |=> (rsp_wb_o && rsp_data_o[DATA_W-1:1] == '0));
endmodule

// File: tb/lsu_unit_test.sv
module lsu_unit_test;
  import lsu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [31:0] base = '0;
  logic [15:0] disp = '0;
  logic [31:0] wdata = '0;
  logic        snoop_we = 1'b0;
  logic [29:0] snoop_wa = '0;
  logic        mem_re, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_wb, rsp_err;
  logic [31:0] rsp_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  lsu_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .base_i(base),
    .disp_i(disp), .wdata_i(wdata), .snoop_we_i(snoop_we), .snoop_wa_i(snoop_wa),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rsp_valid_o(rsp_valid),
    .rsp_wb_o(rsp_wb), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data)
  );

  logic [31:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
  end

  // captured request-cycle and response-cycle values
  logic [29:0] c_wa;
  logic [3:0]  c_be;
  logic        c_we, c_re, r_valid, r_wb, r_err;
  logic [31:0] c_wdata, r_data;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [31:0] b, input logic [15:0] d, input logic [31:0] w);
    @(negedge clk);
    req = 1'b1; op = o; base = b; disp = d; wdata = w;
    #1;
    c_wa = mem_addr; c_be = mem_be; c_we = mem_we; c_re = mem_re; c_wdata = mem_wdata;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    r_valid = rsp_valid; r_wb = rsp_wb; r_err = rsp_err; r_data = rsp_data;
  endtask

  task automatic snoop(input logic [29:0] wa);
    @(negedge clk);
    snoop_we = 1'b1; snoop_wa = wa;
    @(negedge clk);
    snoop_we = 1'b0;
  endtask

  task automatic expect_load(input logic [3:0] o, input logic [31:0] addr, input logic [31:0] exp, input string tag);
    run_op(o, addr, 16'h0, 32'h0);
    check(r_valid && r_wb && r_data == exp, tag, r_data, exp);
  endtask

  // op, base, disp, wdata, expected word address, expected byte enables, expected result
  localparam int NV = 19;
  localparam logic [151:0] VEC [NV] = '{
    {OP_SW,  32'h10,       16'h0000, 32'h80F17F02, 32'h4,    4'hF, 32'h0},
    {OP_LW,  32'h14,       16'hFFFC, 32'h0,        32'h4,    4'h0, 32'h80F17F02},
    {OP_LB,  32'h10,       16'h0002, 32'h0,        32'h4,    4'h0, 32'hFFFFFFF1},
    {OP_LBU, 32'h10,       16'h0002, 32'h0,        32'h4,    4'h0, 32'h000000F1},
    {OP_LB,  32'h10,       16'h0001, 32'h0,        32'h4,    4'h0, 32'h0000007F},
    {OP_LH,  32'h10,       16'h0002, 32'h0,        32'h4,    4'h0, 32'hFFFF80F1},
    {OP_LHU, 32'h10,       16'h0002, 32'h0,        32'h4,    4'h0, 32'h000080F1},
    {OP_LH,  32'h10,       16'h0000, 32'h0,        32'h4,    4'h0, 32'h00007F02},
    {OP_SB,  32'h20,       16'h0003, 32'h000000A5, 32'h8,    4'h8, 32'h0},
    {OP_SH,  32'h20,       16'h0000, 32'h0000C3D4, 32'h8,    4'h3, 32'h0},
    {OP_LW,  32'h20,       16'h0000, 32'h0,        32'h8,    4'h0, 32'hA500C3D4},
    {OP_SB,  32'h21,       16'h0000, 32'h00000011, 32'h8,    4'h2, 32'h0},
    {OP_SH,  32'h1E,       16'h0004, 32'h0000BEEF, 32'h8,    4'hC, 32'h0},
    {OP_LW,  32'h20,       16'h0000, 32'h0,        32'h8,    4'h0, 32'hBEEF11D4},
    {OP_LHU, 32'h22,       16'h0000, 32'h0,        32'h8,    4'h0, 32'h0000BEEF},
    {OP_LB,  32'h23,       16'h0000, 32'h0,        32'h8,    4'h0, 32'hFFFFFFBE},
    {OP_SW,  32'h00010030, 16'h8000, 32'h12345678, 32'h200C, 4'hF, 32'h0},
    {OP_LW,  32'h8030,     16'h0000, 32'h0,        32'h200C, 4'h0, 32'h12345678},
    {OP_LBU, 32'h8031,     16'h0000, 32'h0,        32'h200C, 4'h0, 32'h00000056}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rsp_valid && !mem_we && !mem_re, "R1 reset outputs", {29'b0, rsp_valid, mem_we, mem_re}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: no reservation after reset
    run_op(OP_SC, 32'h30, 16'h0, 32'h55);
    check(!c_we && r_wb && r_data == 32'h0, "R10 sc after reset", r_data, 32'h0);
    expect_load(OP_LW, 32'h30, 32'h0, "R10 memory untouched");

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  v_op;
      logic [31:0] v_base, v_wd, v_wa, v_res;
      logic [15:0] v_disp;
      logic [3:0]  v_be;
      {v_op, v_base, v_disp, v_wd, v_wa, v_be, v_res} = VEC[i];
      run_op(v_op, v_base, v_disp, v_wd);
      check(c_wa == v_wa[29:0], "R2 word address", {2'b0, c_wa}, v_wa);
      check(r_valid, "R1 response valid", {31'b0, r_valid}, 32'h1);
      if (v_op[3]) begin
        check(c_we && c_be == v_be, "R3 store enables", {27'b0, c_we, c_be}, {27'b0, 1'b1, v_be});
        check(!r_wb, "R1 store no writeback", {31'b0, r_wb}, 32'h0);
      end else begin
        case (v_op)
          OP_LB, OP_LH:   check(r_wb && r_data == v_res, "R6 signed load", r_data, v_res);
          OP_LBU, OP_LHU: check(r_wb && r_data == v_res, "R5 unsigned load", r_data, v_res);
          default:        check(r_wb && r_data == v_res, "R7 word load / R4 lanes", r_data, v_res);
        endcase
      end
    end

    // R4: lane replication
    run_op(OP_SH, 32'h20, 16'h0, 32'h1234C3D4);
    check(c_wdata == 32'hC3D4C3D4, "R4 half replicate", c_wdata, 32'hC3D4C3D4);
    run_op(OP_SB, 32'h21, 16'h0, 32'hFFFFFF5A);
    check(c_wdata == 32'h5A5A5A5A, "R4 byte replicate", c_wdata, 32'h5A5A5A5A);

    // R8: misalignment
    run_op(OP_LH, 32'h11, 16'h0, 32'h0);
    check(r_err && !r_wb && !c_re && !c_we, "R8 misaligned half load", {28'b0, r_err, r_wb, c_re, c_we}, 32'h8);
    run_op(OP_SW, 32'h12, 16'h0, 32'hFFFFFFFF);
    check(r_err && !r_wb && !c_we, "R8 misaligned word store", {29'b0, r_err, r_wb, c_we}, 32'h4);
    expect_load(OP_LW, 32'h10, 32'h80F17F02, "R8 no write after misaligned store");

    // R10: plain sc with no reservation
    run_op(OP_SC, 32'h30, 16'h0, 32'hAA);
    check(r_data == 32'h0, "R10 sc without ll", r_data, 32'h0);
    expect_load(OP_LW, 32'h30, 32'h12345678, "R10 failed sc kept memory");

    // R9 / R7 / R12
    expect_load(OP_LL, 32'h30, 32'h12345678, "R7 ll returns word");
    run_op(OP_SC, 32'h30, 16'h0, 32'h55);
    check(c_we && r_data == 32'h1, "R9 sc success", r_data, 32'h1);
    expect_load(OP_LW, 32'h30, 32'h55, "R9 sc stored word");
    run_op(OP_SC, 32'h30, 16'h0, 32'h66);
    check(!c_we && r_data == 32'h0, "R12 second sc fails", r_data, 32'h0);
    expect_load(OP_LW, 32'h30, 32'h55, "R12 memory kept");

    // R10: mismatched word
    expect_load(OP_LL, 32'h30, 32'h55, "R7 ll again");
    run_op(OP_SC, 32'h34, 16'h0, 32'h77);
    check(!c_we && r_data == 32'h0, "R10 sc other word", r_data, 32'h0);
    expect_load(OP_LW, 32'h34, 32'h0, "R10 other word untouched");

    // R11: snoop to the reserved word
    expect_load(OP_LL, 32'h30, 32'h55, "R7 ll snoop case");
    snoop(30'hC);
    run_op(OP_SC, 32'h30, 16'h0, 32'h88);
    check(r_data == 32'h0, "R11 snoop same word cancels", r_data, 32'h0);

    // R11: snoop to another word
    expect_load(OP_LL, 32'h30, 32'h55, "R7 ll snoop other");
    snoop(30'h10);
    run_op(OP_SC, 32'h30, 16'h0, 32'h99);
    check(r_data == 32'h1, "R11 snoop other word keeps", r_data, 32'h1);

    // R11: local store to the reserved word
    expect_load(OP_LL, 32'h30, 32'h99, "R7 ll store case");
    run_op(OP_SB, 32'h32, 16'h0, 32'h01);
    run_op(OP_SC, 32'h30, 16'h0, 32'hAB);
    check(r_data == 32'h0, "R11 local store cancels", r_data, 32'h0);

    // R11: local store elsewhere
    expect_load(OP_LL, 32'h30, 32'h00010099, "R7 ll store other");
    run_op(OP_SW, 32'h40, 16'h0, 32'hCAFE);
    run_op(OP_SC, 32'h30, 16'h0, 32'hCD);
    check(r_data == 32'h1, "R11 store other word keeps", r_data, 32'h1);
    expect_load(OP_LW, 32'h30, 32'hCD, "R9 sc wrote after unrelated store");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule